// File: doc/BRIEF.md
# Virtual Interrupt Interface Control Registers

This block is the register file that a hypervisor uses to steer the virtual side of an interrupt-controller CPU interface. It keeps one bank of state for each physical CPU. Each bank holds a control word, an active-priorities word and a parameterised set of list registers that describe the pending and active virtual interrupts. The block does not store the empty-slot and end-of-interrupt bitmaps. It decodes them on every read from the state and flag fields of the list registers. A packed machine-control word gives a view of the virtual CPU's control bits, its two binary points and its priority mask. Writes through this word are unpacked and clamped.

Access uses a single-beat register bus. A write takes effect on the clock edge. Read data is combinational in the same cycle as the request. Each access goes to one of two windows. The current-CPU window uses the bank named by `cur_cpu`. A mirror window uses the bank named by `mirror_cpu`, whatever the value of `cur_cpu`. Each bank also exposes the virtual running priority. This value is recomputed whenever its active-priorities word is written.

Top module: `vif_ctl_regs`

## Requirements
- R1: After reset, every control, active-priorities and list register reads zero. Both binary points read at their minimums (binary point 2, aliased binary point 3). The priority mask reads zero, and every running priority output is 8'hFF.
- R2: With `mirror_sel`=1 an access addresses bank `mirror_cpu`. With `mirror_sel`=0 it addresses bank `cur_cpu`. An access never touches the other bank. Read data is zero whenever no read is requested.
- R3: Empty-slot words at offsets 0x030 (list registers 0..31) and 0x034 (32..63) have bit n%32 set for list register n when its state field [29:28] is 00 and either its hardware bit [31] is 1 or its EOI-request bit [19] is 0.
- R4: EOI-status words at offsets 0x020 and 0x024 have bit n%32 set for list register n only when [29:28] is 00, [31] is 0 and [19] is 1.
- R5: The type word at 0x004 reads {(7-MIN_BP)-1 in [31:29], PRE_BITS-1 in [28:26], NUM_LR-1 in [5:0]} with all other bits zero.
- R6: The machine-control word at 0x008 reads the priority mask bits [7:3] in [31:27], the binary point in [23:21], the aliased binary point in [20:18] and the 10-bit control in [9:0]. All other bits read zero.
- R7: A write to 0x008 stores control = wdata[9:0] and priority mask = {wdata[31:27],3'b000}. It stores each binary point as the larger of the written value and its minimum.
- R8: A write to the control word at 0x000 keeps only the bits of 32'hF800_00FF. Bits [26:8] always read zero.
- R9: List register i sits at offset 0x100+4*i. Writes keep only the bits of 32'hFF8F_FFFF, so bits [22:20] read zero.
- R10: A list-register offset whose index is NUM_LR or more reads zero, and a write to it changes no register.
- R11: Any offset not listed in R3 to R12 reads zero, and a write to it changes no register.
- R12: The active-priorities word at 0x0F0 reads back as written. Writing it sets that bank's running priority to 8'hFF if the value is zero. Otherwise the running priority becomes the index of the lowest set bit shifted left by MIN_BP+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| cur_cpu | input | CW | Bank used by the current-CPU window |
| mirror_sel | input | 1 | 1 = access comes through a mirror window |
| mirror_cpu | input | CW | Bank fixed by the mirror window in use |
| rdata | output | 32 | Combinational read data |
| vrun_prio | output | 8*NUM_CPU | Running priority per bank, bank k in bits [8k+7:8k] |

## Verification
The collision that matters is a mirror-window access made while `cur_cpu` names a different bank. The bench randomises `cur_cpu` on every access, independently of `mirror_cpu`, and compares each read with a model that has no knowledge of the hardware's internals. A wrong bank choice therefore shows up as stale or foreign data. A second overlap is a list-register write followed at once by a status-bitmap read. The bench places these back to back and expects the derived bitmaps to reflect the new entry on the very next cycle.

// File: rtl/vif_ctl_regs.sv
module vif_ctl_regs #(
  parameter int NUM_CPU  = 2,
  parameter int NUM_LR   = 4,
  parameter int MIN_BP   = 2,
  parameter int MIN_ABP  = 3,
  parameter int PRE_BITS = 5,
  parameter logic [31:0] HCR_MASK = 32'hF800_00FF,
  parameter logic [31:0] LR_MASK  = 32'hFF8F_FFFF,
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [CW-1:0]        cur_cpu,
  input  logic                 mirror_sel,
  input  logic [CW-1:0]        mirror_cpu,
  output logic [31:0]          rdata,
  output logic [NUM_CPU*8-1:0] vrun_prio
);

  localparam int LW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1;
  localparam logic [11:0] OFS_CTL  = 12'h000;
  localparam logic [11:0] OFS_TYPE = 12'h004;
  localparam logic [11:0] OFS_MCTL = 12'h008;
  localparam logic [11:0] OFS_EOI0 = 12'h020;
  localparam logic [11:0] OFS_EOI1 = 12'h024;
  localparam logic [11:0] OFS_EMP0 = 12'h030;
  localparam logic [11:0] OFS_EMP1 = 12'h034;
  localparam logic [11:0] OFS_ACTP = 12'h0F0;
  localparam logic [31:0] TYPE_VAL = {3'((7 - MIN_BP) - 1), 3'(PRE_BITS - 1), 20'd0, 6'(NUM_LR - 1)};

  logic [31:0] ctl_q  [NUM_CPU];
  logic [31:0] actp_q [NUM_CPU];
  logic [9:0]  vctl_q [NUM_CPU];
  logic [2:0]  bp_q   [NUM_CPU];
  logic [2:0]  abp_q  [NUM_CPU];
  logic [7:0]  pm_q   [NUM_CPU];
  logic [7:0]  rp_q   [NUM_CPU];
  logic [31:0] lr_q   [NUM_CPU][NUM_LR];

  function automatic logic [2:0] floor_to(input logic [2:0] v, input logic [2:0] m);
    return (v < m) ? m : v;
  endfunction

  function automatic logic [7:0] prio_of(input logic [31:0] a);
    logic [4:0] idx;
    idx = '0;
    for (int b = 31; b >= 0; b--) if (a[b]) idx = 5'(b);
    return (a == '0) ? 8'hFF : 8'({3'b000, idx} << (MIN_BP + 1));
  endfunction

  logic [CW-1:0] bank_sel;
  logic          bank_ok;
  logic [CW-1:0] bi;
  logic          lr_hit, lr_ok;
  logic [5:0]    lr_idx;
  logic [LW-1:0] li;
  logic          rd_en, wr_en;

  assign bank_sel = mirror_sel ? mirror_cpu : cur_cpu;
  assign bank_ok  = int'(bank_sel) < NUM_CPU;
  assign bi       = bank_ok ? bank_sel : '0;
  assign lr_hit   = (req_addr[11:8] == 4'h1) && (req_addr[1:0] == 2'b00);
  assign lr_idx   = req_addr[7:2];
  assign lr_ok    = lr_hit && (int'(lr_idx) < NUM_LR);
  assign li       = lr_ok ? lr_idx[LW-1:0] : '0;
  assign rd_en    = req_valid && !req_write && bank_ok;
  assign wr_en    = req_valid && req_write && bank_ok;

  logic [63:0] empty_v, eoi_v;
  always_comb begin
    empty_v = '0;
    eoi_v   = '0;
    for (int k = 0; k < NUM_LR; k++) begin
      empty_v[k] = (lr_q[bi][k][29:28] == 2'b00) && (lr_q[bi][k][31] || !lr_q[bi][k][19]);
      eoi_v[k]   = (lr_q[bi][k][29:28] == 2'b00) && !lr_q[bi][k][31] && lr_q[bi][k][19];
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (lr_ok) rd_mux = lr_q[bi][li];
    else case (req_addr)
      OFS_CTL:  rd_mux = ctl_q[bi];
      OFS_TYPE: rd_mux = TYPE_VAL;
      OFS_MCTL: rd_mux = {pm_q[bi][7:3], 3'b000, bp_q[bi], abp_q[bi], 8'd0, vctl_q[bi]};
      OFS_EOI0: rd_mux = eoi_v[31:0];
      OFS_EOI1: rd_mux = eoi_v[63:32];
      OFS_EMP0: rd_mux = empty_v[31:0];
      OFS_EMP1: rd_mux = empty_v[63:32];
      OFS_ACTP: rd_mux = actp_q[bi];
      default:  rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        ctl_q[c]  <= '0;
        actp_q[c] <= '0;
        vctl_q[c] <= '0;
        bp_q[c]   <= 3'(MIN_BP);
        abp_q[c]  <= 3'(MIN_ABP);
        pm_q[c]   <= '0;
        rp_q[c]   <= 8'hFF;
        for (int k = 0; k < NUM_LR; k++) lr_q[c][k] <= '0;
      end
    end else if (wr_en) begin
      if (lr_ok) lr_q[bi][li] <= req_wdata & LR_MASK;
      else case (req_addr)
        OFS_CTL: ctl_q[bi] <= req_wdata & HCR_MASK;
        OFS_MCTL: begin
          vctl_q[bi] <= req_wdata[9:0];
          pm_q[bi]   <= {req_wdata[31:27], 3'b000};
          bp_q[bi]   <= floor_to(req_wdata[23:21], 3'(MIN_BP));
          abp_q[bi]  <= floor_to(req_wdata[20:18], 3'(MIN_ABP));
        end
        OFS_ACTP: begin
          actp_q[bi] <= req_wdata;
          rp_q[bi]   <= prio_of(req_wdata);
        end
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    assign vrun_prio[c*8 +: 8] = rp_q[c];

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (actp_q[c] == '0) |-> (rp_q[c] == 8'hFF)); // R12
    AST_BP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_q[c] >= 3'(MIN_BP)) && (abp_q[c] >= 3'(MIN_ABP))); // R7
    AST_PMASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pm_q[c][2:0] == 3'b000); // R7
    AST_CTL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[c] & ~HCR_MASK) == '0); // R8
    for (genvar k = 0; k < NUM_LR; k++) begin : g_lr
      AST_LR_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_q[c][k] & ~LR_MASK) == '0); // R9
    end
  end

  AST_FAR_LR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && lr_hit && !lr_ok) |-> (rdata == '0)); // R10
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (rdata == '0)); // R2

endmodule

// File: tb/vif_ctl_regs_bench.sv
module vif_ctl_regs_bench;
  localparam int NC = 2;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, mirror_sel = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [0:0]  cur_cpu = '0, mirror_cpu = '0;
  logic [31:0] rdata;
  logic [15:0] vrun_prio;

  vif_ctl_regs u_vif_ctl_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cur_cpu(cur_cpu),
    .mirror_sel(mirror_sel), .mirror_cpu(mirror_cpu), .rdata(rdata),
    .vrun_prio(vrun_prio));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit reset_phase = 0;

  int unsigned m_ctl[NC], m_actp[NC], m_vctl[NC], m_bp[NC], m_abp[NC], m_pm[NC], m_rp[NC];
  int unsigned m_lr[NC][NL];

  function automatic string tag_of(int unsigned a);
    if (reset_phase) return "R1";
    if (mirror_sel && cur_cpu != mirror_cpu) return "R2";
    if (a >= 'h100 && a < 'h200 && a % 4 == 0) return ((a - 'h100) / 4 < NL) ? "R9" : "R10";
    case (a)
      'h000: return "R8";
      'h004: return "R5";
      'h008: return "R6";
      'h020, 'h024: return "R4";
      'h030, 'h034: return "R3";
      'h0F0: return "R12";
      default: return "R11";
    endcase
  endfunction

  function automatic int unsigned model_read(int unsigned a, int c);
    int unsigned r = 0;
    if (a >= 'h100 && a < 'h200 && a % 4 == 0) begin
      if ((a - 'h100) / 4 < NL) r = m_lr[c][(a - 'h100) / 4];
      return r;
    end
    case (a)
      'h000: r = m_ctl[c];
      'h004: r = (4 << 29) | (4 << 26) | (NL - 1);
      'h008: r = ((m_pm[c] >> 3) << 27) | (m_bp[c] << 21) | (m_abp[c] << 18) | m_vctl[c];
      'h020, 'h024, 'h030, 'h034:
        for (int k = 0; k < NL; k++) begin
          bit inv, hw, eo, hitb;
          inv = ((m_lr[c][k] >> 28) & 3) == 0;
          hw  = m_lr[c][k][31];
          eo  = m_lr[c][k][19];
          hitb = (a < 'h030) ? (inv && !hw && eo) : (inv && (hw || !eo));
          if (hitb && (k / 32) == ((a % 16) / 4)) r |= 1 << (k % 32);
        end
      'h0F0: r = m_actp[c];
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic model_write(int unsigned a, int unsigned d, int c);
    if (a >= 'h100 && a < 'h200 && a % 4 == 0) begin
      if ((a - 'h100) / 4 < NL) m_lr[c][(a - 'h100) / 4] = d & 32'hFF8F_FFFF;
      return;
    end
    case (a)
      'h000: m_ctl[c] = d & 32'hF800_00FF;
      'h008: begin
        m_vctl[c] = d & 'h3FF;
        m_pm[c]   = ((d >> 27) & 'h1F) * 8;
        m_bp[c]   = ((d >> 21) & 7) < 2 ? 2 : ((d >> 21) & 7);
        m_abp[c]  = ((d >> 18) & 7) < 3 ? 3 : ((d >> 18) & 7);
      end
      'h0F0: begin
        m_actp[c] = d;
        m_rp[c] = 255;
        for (int b = 31; b >= 0; b--) if (d[b]) m_rp[c] = b * 8;
      end
      default: ;
    endcase
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_ctl[c] = 0; m_actp[c] = 0; m_vctl[c] = 0; m_bp[c] = 2; m_abp[c] = 3;
      m_pm[c] = 0; m_rp[c] = 255;
      for (int k = 0; k < NL; k++) m_lr[c][k] = 0;
    end
  endtask

  task automatic op(bit v, bit w, int unsigned a, int unsigned d, bit cc, bit ms, bit mc);
    int bank;
    int unsigned exp_r;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a[11:0]; req_wdata = d;
    cur_cpu = cc; mirror_sel = ms; mirror_cpu = mc;
    #1;
    bank = ms ? mc : cc;
    exp_r = (v && !w) ? model_read(a, bank) : 0;
    n_cmp++;
    if (rdata !== exp_r) begin
      n_bad++;
      $display("FAIL %s rdata addr=%03h bank=%0d actual=%08h expected=%08h", tag_of(a), a, bank, rdata, exp_r);
    end
    for (int c = 0; c < NC; c++) begin
      n_cmp++;
      if (vrun_prio[c*8 +: 8] !== 8'(m_rp[c])) begin
        n_bad++;
        $display("FAIL %s vrun_prio bank=%0d actual=%02h expected=%02h", reset_phase ? "R1" : "R12",
                 c, vrun_prio[c*8 +: 8], 8'(m_rp[c]));
      end
    end
    if (v && w) model_write(a, d, bank);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  int unsigned offs[12] = '{'h000, 'h004, 'h008, 'h020, 'h024, 'h030, 'h034, 'h0F0, 'h100, 'h10C, 'h110, 'h00C};

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of both banks
    reset_phase = 1;
    for (int c = 0; c < NC; c++)
      foreach (offs[i]) op(1, 0, offs[i], 0, c[0], 0, 0);
    op(0, 0, 'h000, 0, 0, 0, 0);
    reset_phase = 0;
    // R8, R6, R7: masking and clamping
    op(1, 1, 'h000, 32'hFFFF_FFFF, 0, 0, 0);
    op(1, 0, 'h000, 0, 0, 0, 0);
    op(1, 1, 'h008, 32'hFFFF_FFFF, 1, 0, 0);
    op(1, 0, 'h008, 0, 1, 0, 0);
    op(1, 1, 'h008, 32'h0000_0000, 1, 0, 0);
    op(1, 0, 'h008, 0, 1, 0, 0);
    op(1, 1, 'h008, (32'd5 << 21) | (32'd4 << 18) | (32'h0A << 27) | 32'h155, 0, 0, 0);
    op(1, 0, 'h008, 0, 0, 0, 0);
    // R3, R4, R9: list entries then status words immediately after
    op(1, 1, 'h100, 32'h0008_0000, 0, 0, 0);
    op(1, 0, 'h020, 0, 0, 0, 0);
    op(1, 0, 'h030, 0, 0, 0, 0);
    op(1, 1, 'h104, 32'h8008_0000, 0, 0, 0);
    op(1, 0, 'h030, 0, 0, 0, 0);
    op(1, 1, 'h108, 32'h1008_0000, 0, 0, 0);
    op(1, 0, 'h030, 0, 0, 0, 0);
    op(1, 0, 'h020, 0, 0, 0, 0);
    op(1, 1, 'h10C, 32'hFFFF_FFFF, 0, 0, 0);
    op(1, 0, 'h10C, 0, 0, 0, 0);
    // R10, R11: far list index and unknown offsets
    op(1, 1, 'h110, 32'hFFFF_FFFF, 0, 0, 0);
    op(1, 0, 'h110, 0, 0, 0, 0);
    op(1, 1, 'h1FC, 32'h1234_5678, 0, 0, 0);
    op(1, 1, 'h00C, 32'hFFFF_FFFF, 0, 0, 0);
    op(1, 1, 'h102, 32'hFFFF_FFFF, 0, 0, 0);
    op(1, 0, 'h100, 0, 0, 0, 0);
    op(1, 0, 'h00C, 0, 0, 0, 0);
    // R12: running priority
    op(1, 1, 'h0F0, 32'h0000_0010, 0, 0, 0);
    op(1, 0, 'h0F0, 0, 0, 0, 0);
    op(1, 1, 'h0F0, 32'h8000_0000, 1, 0, 0);
    op(1, 1, 'h0F0, 32'h0000_0000, 0, 0, 0);
    // R2: mirror window against a different current bank
    op(1, 1, 'h104, 32'h2000_0001, 0, 1, 1);
    op(1, 0, 'h104, 0, 0, 0, 0);
    op(1, 0, 'h104, 0, 0, 1, 1);
    op(1, 0, 'h104, 0, 1, 0, 0);
    // random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned a, d;
      a = ($urandom % 4 == 0) ? ($urandom % 'h200) & ~3 : offs[$urandom % 12];
      if ($urandom % 4 == 0) a = 'h100 + 4 * ($urandom % 6);
      d = $urandom;
      if ($urandom % 2) d[29:28] = 2'b00;
      if (a == 'h0F0 && $urandom % 2) d = 1 << ($urandom % 32);
      op($urandom % 8 != 0, $urandom % 2, a, d, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule